// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block generates the system reset for a processor subsystem. Three events can start a reset: power-up, a low supply reported by a synchronous supply-good flag, and a watchdog that nobody serviced in time. A single stretch counter handles every reset cause. After the cause goes away, reset stays active for a programmable number of clock ticks, so the rest of the system starts from a quiet, stable state.

The watchdog runs only while reset is inactive. Firmware restarts it with a one-cycle kick strobe. A 2-bit select picks one of three timeout lengths, or turns the watchdog off. The select comes from a register that keeps its value across power cycles, so the block samples it as an ordinary input every cycle. The reset is driven as two open-drain pull enables, one for each output polarity.

Top module: `sup_reset_seq`

## Requirements
- R1: While `por_n` is low, `rst_lo_pull` is 1 and `rst_hi_pull` is 0. After `por_n` rises, with `supply_ok` high, reset is released after exactly HOLD_TICKS rising edges.
- R2: Reset is active from the first rising edge that samples `supply_ok` low, and stays active for as long as `supply_ok` is low.
- R3: Once `supply_ok` returns high, reset is released after HOLD_TICKS consecutive edges with `supply_ok` high. A new low sample restarts this count.
- R4: With no kicks, the watchdog asserts reset after the limit for the select. The limit is counted in edges from the release of reset. Encoding: 2'b00 gives T_SHORT, 2'b01 gives T_MED and 2'b10 gives T_LONG.
- R5: Select 2'b11 turns the watchdog off. No watchdog reset occurs, with or without kicks.
- R6: A kick sampled on an edge restarts the count from zero. This includes a kick on the edge where the limit would be reached, which prevents the timeout.
- R7: A watchdog timeout holds reset active for HOLD_TICKS edges, the same length as the power-on hold.
- R8: The watchdog count is cleared while reset is active. Kicks during reset do not change the hold length, and the next timeout is counted from the release.
- R9: The two outputs are always complementary. `rst_lo_pull`=1 means reset is active, and `rst_hi_pull`=1 means reset is inactive.
- R10: If the select changes to a limit that the elapsed count already meets or exceeds, reset is asserted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every delay is counted in its ticks |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| supply_ok | input | 1 | Synchronous supply-above-trip flag |
| wd_kick | input | 1 | One-cycle watchdog restart strobe |
| wd_sel | input | 2 | Watchdog interval select held in retained storage |
| rst_lo_pull | output | 1 | Pull enable for the active-low reset pin (1 while reset is active) |
| rst_hi_pull | output | 1 | Pull enable for the active-high reset pin (1 while reset is inactive) |

## Verification
The bench builds the block with HOLD_TICKS=8 and watchdog limits of 10, 20 and 40 ticks. This lets every hold period and every timeout run to completion within a few hundred cycles. With these short values, the bench can check the exact edge counts: a kick on the limit edge, a kick one edge too late, a select change after the count has passed a shorter limit, and a supply glitch partway through the hold.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MED   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Tick limit for a select value; zero stands for "no limit" (watchdog off).
  function automatic int unsigned wd_limit(wd_sel_e s, int unsigned t_short,
                                           int unsigned t_med, int unsigned t_long);
    case (s)
      WD_SHORT: return t_short;
      WD_MED:   return t_med;
      WD_LONG:  return t_long;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned HOLD_TICKS = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic active
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] LAST_C = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          done;

  assign done   = (cnt == HOLD_C);
  assign active = !done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt <= '0;
    else if (trig)   cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

  // A trigger always leaves reset active on the following cycle.
  assert_trig_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> active);

  // Release only happens when the count has run through the whole hold.
  assert_full_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> ($past(cnt) == LAST_C && !$past(trig)));

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned T_SHORT = 16384,
  parameter int unsigned T_MED   = 65536,
  parameter int unsigned T_LONG  = 262144
) (
  input  logic    clk,
  input  logic    por_n,
  input  logic    hold,
  input  logic    kick,
  input  wd_sel_e sel,
  output logic    expire
);
  localparam int unsigned TMAX = max3(T_SHORT, T_MED, T_LONG);
  localparam int unsigned WW   = $clog2(TMAX + 1);

  logic [WW-1:0] wcnt;
  logic          run;
  int unsigned   lim;
  logic          at_limit;

  assign lim      = wd_limit(sel, T_SHORT, T_MED, T_LONG);
  assign run      = !hold && (sel != WD_OFF);
  assign at_limit = (32'(wcnt) + 32'd1) >= lim;
  assign expire   = run && !kick && at_limit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        wcnt <= '0;
    else if (!run || kick || expire)   wcnt <= '0;
    else                               wcnt <= wcnt + 1'b1;
  end

  // Reset in progress keeps the timer at zero for the next cycle.
  assert_idle_in_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
    hold |=> (wcnt == '0));

  // A kick restarts the count.
  assert_kick_restarts_R6: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> (wcnt == '0));

  // A disabled watchdog never times out.
  assert_off_silent_R5: assert property (@(posedge clk) disable iff (!por_n)
    ($past(sel) == WD_OFF && sel == WD_OFF) |-> !expire);

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 4096,
  parameter int unsigned T_SHORT    = 16384,
  parameter int unsigned T_MED      = 65536,
  parameter int unsigned T_LONG     = 262144
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_ok,
  input  logic       wd_kick,
  input  logic [1:0] wd_sel,
  output logic       rst_lo_pull,
  output logic       rst_hi_pull
);
  logic rst_act;
  logic wd_expire;
  logic trig;

  assign trig = !supply_ok || wd_expire;

  sup_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_stretch (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (trig),
    .active (rst_act)
  );

  sup_wdog #(.T_SHORT(T_SHORT), .T_MED(T_MED), .T_LONG(T_LONG)) u_wdog (
    .clk    (clk),
    .por_n  (por_n),
    .hold   (rst_act),
    .kick   (wd_kick),
    .sel    (wd_sel_e'(wd_sel)),
    .expire (wd_expire)
  );

  assign rst_lo_pull = rst_act;
  assign rst_hi_pull = !rst_act;

  // Low supply at an edge means reset in the next cycle.
  assert_low_supply_R2: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> rst_lo_pull);

  // A watchdog timeout means reset in the next cycle.
  assert_wd_fire_R7: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> rst_lo_pull);

  // Release never follows a low supply sample directly.
  assert_quiet_release_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_hi_pull) |-> $past(supply_ok));

endmodule

// File: tb/sup_reset_seq_tb.sv
module sup_reset_seq_tb;
  localparam int HOLD = 8;
  localparam int TS = 10, TM = 20, TL = 40;
  localparam int WIN = 200;

  localparam int NV = 10;
  // sel, kick period (0 = never), expected released run length (0 = none in window)
  localparam int V_SEL[NV]  = '{0, 1, 2, 3, 0,  0,  1,  2,  2, 3};
  localparam int V_PER[NV]  = '{0, 0, 0, 0, 10, 11, 19, 40, 41, 5};
  localparam int V_EXP[NV]  = '{TS, TM, TL, 0, 0, TS, 0, 0, TL, 0};

  logic clk = 0;
  logic por_n = 0;
  logic supply_ok = 1;
  logic wd_kick = 0;
  logic [1:0] wd_sel = 2'b11;
  logic rst_lo_pull, rst_hi_pull;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  sup_reset_seq #(.HOLD_TICKS(HOLD), .T_SHORT(TS), .T_MED(TM), .T_LONG(TL)) u_dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .wd_kick(wd_kick),
    .wd_sel(wd_sel), .rst_lo_pull(rst_lo_pull), .rst_hi_pull(rst_hi_pull)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL run-limit actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // Count negedges until reset releases (returns WIN+1 if never).
  task automatic count_hold(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (rst_lo_pull && n <= WIN);
  endtask

  // From a released state, count negedges until reset, kicking with period per.
  task automatic count_run(input int per, input int sw_at, input logic [1:0] sw_sel,
                           output int n);
    n = 0;
    while (n < WIN) begin
      @(negedge clk);
      wd_kick = 0;
      n++;
      if (rst_lo_pull) return;
      if (per != 0 && ((n + 1) % per) == 0) wd_kick = 1;
      if (n == sw_at) wd_sel = sw_sel;
    end
    n = 0;
  endtask

  task automatic supply_dip(input int len);
    for (int i = 0; i < len; i++) begin
      supply_ok = 0;
      @(negedge clk);
    end
    supply_ok = 1;
  endtask

  initial begin
    int n;
    @(negedge clk);
    chk("R1 lo pull in power-up reset", int'(rst_lo_pull), 1);
    chk("R9 hi pull in power-up reset", int'(rst_hi_pull), 0);
    repeat (3) @(negedge clk);
    por_n = 1;
    count_hold(n);
    chk("R1 power-up hold edges", n, HOLD);
    chk("R9 hi pull after release", int'(rst_hi_pull), 1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      wd_sel = 2'(V_SEL[v]);
      supply_dip(1);
      chk("R2 reset after one low sample", int'(rst_lo_pull), 1);
      count_hold(n);
      chk("R3 recovery hold edges", n, HOLD);
      count_run(V_PER[v], -1, 2'b00, n);
      wd_kick = 0;
      chk((V_SEL[v] == 3) ? "R5 watchdog off" :
          (V_PER[v] != 0) ? "R6 kick timing" : "R4 timeout length", n, V_EXP[v]);
      if (n != 0) begin
        count_hold(n);
        chk("R7 watchdog reset hold", n, HOLD - 1 + 1);
      end
    end

    // Long low supply keeps reset active
    wd_sel = 2'b11;
    supply_ok = 0;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!rst_lo_pull || rst_hi_pull) n++;
    end
    chk("R2 reset held during long low", n, 0);
    supply_ok = 1;
    count_hold(n);
    chk("R3 hold after long low", n, HOLD);

    // Glitch during recovery restarts the count
    supply_dip(1);
    repeat (3) @(negedge clk);
    chk("R3 still held mid recovery", int'(rst_lo_pull), 1);
    supply_dip(1);
    count_hold(n);
    chk("R3 hold restarted by glitch", n, HOLD);

    // Kicks during reset: hold unchanged, timer starts at release
    wd_sel = 2'b00;
    supply_dip(1);
    n = 0;
    do begin
      wd_kick = 1;
      @(negedge clk);
      n++;
    end while (rst_lo_pull && n <= WIN);
    wd_kick = 0;
    chk("R8 hold with kicks during reset", n, HOLD);
    count_run(0, -1, 2'b00, n);
    chk("R8 timeout counted from release", n, TS);
    count_hold(n);

    // Select shortened after the count has passed the new limit
    wd_sel = 2'b10;
    count_run(0, 29, 2'b00, n);
    chk("R10 shortened select fires next edge", n, 30);
    count_hold(n);

    // Select retained across a power cycle
    wd_sel = 2'b01;
    por_n = 0;
    @(negedge clk);
    chk("R1 reset during second power-up", int'(rst_lo_pull), 1);
    por_n = 1;
    count_hold(n);
    chk("R1 second power-up hold", n, HOLD);
    count_run(0, -1, 2'b00, n);
    chk("R4 retained select after power cycle", n, TM);

    finish_run();
  end
endmodule